// File: doc/BRIEF.md
# CAN Update Frame Classifier

This block sits behind a CAN controller that has already decoded frames. It receives 29-bit extended identifiers with eight data bytes and a one-cycle valid strobe. For each frame it decides whether the local node is the intended receiver. It then sorts the frames it accepts into two kinds: firmware-update control frames and firmware-update image frames.

Image frames are replayed as a stream of eight bytes on consecutive cycles. Each byte carries its image address. Control frames are presented for one cycle, split into a 32-bit type word and a 32-bit message word.

A running unsigned byte sum covers the image bytes since the last checksum command. A control frame whose type equals the parameter `CHK_CODE` compares that sum with its message word and pulses a match or mismatch flag. On a match, the current address becomes the new block start. On a mismatch, the address counter rewinds to the block start, so that the host can resend the block. The host sends these blocks in 64 kB units and pads the last frame with 0xFF.

The control state machine has three states:

- `ST_IDLE` waits for an accepted frame. It takes `T_DATA` to `ST_STREAM` or `T_CTRL` to `ST_CTRL`.
- `ST_STREAM` emits eight bytes. It takes `T_STREAM_END` back to `ST_IDLE` after the eighth byte.
- `ST_CTRL` presents the control words for one cycle. It takes `T_CTRL_END` back to `ST_IDLE`.

Top module: `can_upd_classifier`

## Requirements
- R1: After reset, `byte_valid`, `ctl_valid`, `sum_ok` and `sum_bad` are low, and `byte_addr` is 0.
- R2: A frame whose identifier bit 28 is 1 (sent by a node, not the host) is dropped.
- R3: If identifier bit 27 is 0, the frame is a broadcast and is accepted whatever bits 26:19 hold. If bit 27 is 1, the frame is accepted only when bits 26:19 equal `node_id`.
- R4: Identifier bits 7:0 select the kind: 9 is control and 10 is image data. Any other value drops the frame. Bits 18:8 are ignored.
- R5: An accepted data frame strobed at edge k produces `byte_valid` on the 8 cycles that follow edge k. Data bits 63:56 come first and bits 7:0 come last. `byte_addr` starts at the current image address and rises by one per byte.
- R6: An accepted control frame strobed at edge k gives `ctl_valid` for exactly the cycle after edge k. In that cycle, `ctl_type` equals data bits 63:32 and `ctl_msg` equals data bits 31:0.
- R7: A strobe that arrives while a frame is being streamed or presented is ignored.
- R8: A control frame with type `CHK_CODE` compares the 32-bit sum of all image bytes since the previous checksum frame with its message word. It raises `sum_ok` on equality and `sum_bad` otherwise, in the same cycle as `ctl_valid`. Other control types raise neither flag.
- R9: Every checksum frame clears the running sum, whether it matches or not.
- R10: After a mismatch, the next image byte takes the address of the block start. After a match, the block start moves to the current address, so the address continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| node_id | input | 8 | number of this node (1 upward) |
| frm_valid | input | 1 | one-cycle strobe for a decoded frame |
| frm_id | input | 29 | extended identifier |
| frm_data | input | 64 | eight data bytes, first byte in bits 63:56 |
| byte_valid | output | 1 | image byte present |
| byte_data | output | 8 | image byte |
| byte_addr | output | ADDR_W | image address of the byte |
| ctl_valid | output | 1 | control frame present |
| ctl_type | output | 32 | control type word |
| ctl_msg | output | 32 | control message word |
| sum_ok | output | 1 | checksum frame matched |
| sum_bad | output | 1 | checksum frame did not match |

## Verification
A table of frames covers several identifier patterns:

- broadcast and addressed frames, which separate the broadcast rule from the node-number compare;
- a frame for another node and a frame sent by a node, which show that both the direction bit and the address field are honoured;
- unknown type codes, and reserved bits set, which show that only bits 7:0 select the kind.

Checksum sequences then separate the two outcomes:

- a wrong sum, then a resent block, then a right sum, shows both the rewind and the clearing of the sum;
- an all-0xFF padded frame exercises wide byte values;
- an empty block checked against zero shows that the sum was cleared.

A strobe injected mid-stream tells a correctly ignored overlap from one that is wrongly accepted.

// File: rtl/can_upd_pkg.sv
package can_upd_pkg;
    localparam int ID_W      = 29;
    localparam int NODE_W    = 8;
    localparam int NODE_MSB  = 26;
    localparam int DIR_BIT   = 28;
    localparam int CAST_BIT  = 27;
    localparam int KIND_W    = 8;
    localparam logic [KIND_W-1:0] KIND_CTL = 8'd9;
    localparam logic [KIND_W-1:0] KIND_DAT = 8'd10;
    localparam int FRAME_BYTES = 8;
    localparam int CNT_W       = $clog2(FRAME_BYTES);

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_CTL  = 2'd1,
        CLS_DAT  = 2'd2
    } cls_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_CTRL   = 2'd2
    } st_e;
endpackage

// File: rtl/cuc_id_filter.sv
module cuc_id_filter
    import can_upd_pkg::*;
(
    input  logic              valid,
    input  logic [ID_W-1:0]   id,
    input  logic [NODE_W-1:0] node_id,
    output cls_e              cls
);
    logic from_host;
    logic for_me;
    logic [KIND_W-1:0] kind;

    always_comb begin
        from_host = (id[DIR_BIT] == 1'b0);
        for_me    = (id[CAST_BIT] == 1'b0) ||
                    (id[NODE_MSB -: NODE_W] == node_id);
        kind      = id[KIND_W-1:0];
        cls       = CLS_NONE;
        if (valid && from_host && for_me) begin
            unique case (kind)
                KIND_CTL: cls = CLS_CTL;
                KIND_DAT: cls = CLS_DAT;
                default:  cls = CLS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cuc_checksum.sv
module cuc_checksum #(
    parameter int SUM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [7:0]       add_byte,
    input  logic             clr,
    output logic [SUM_W-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sum <= '0;
        else if (clr)    sum <= '0;
        else if (add_en) sum <= sum + SUM_W'(add_byte);
    end

    AST_SUM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum == '0)); // R9
    AST_SUM_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clr) |=> (sum == $past(sum) + SUM_W'($past(add_byte)))); // R8
endmodule

// File: rtl/cuc_addr_track.sv
module cuc_addr_track #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              commit,
    input  logic              rewind,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] blk_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr      <= '0;
            blk_start <= '0;
        end else begin
            if (rewind)      addr <= blk_start;
            else if (step)   addr <= addr + 1'b1;
            if (commit)      blk_start <= addr;
        end
    end

    AST_REWIND_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (addr == $past(blk_start))); // R10
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !rewind) |=> (addr == $past(addr) + 1'b1)); // R5
    AST_COMMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !step) |=> (addr == $past(addr))); // R10
endmodule

// File: rtl/can_upd_classifier.sv
module can_upd_classifier
    import can_upd_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter logic [31:0] CHK_CODE = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        node_id,
    input  logic              frm_valid,
    input  logic [28:0]       frm_id,
    input  logic [63:0]       frm_data,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic [ADDR_W-1:0] byte_addr,
    output logic              ctl_valid,
    output logic [31:0]       ctl_type,
    output logic [31:0]       ctl_msg,
    output logic              sum_ok,
    output logic              sum_bad
);
    localparam int WORD_W = FRAME_BYTES * 8;

    st_e               state, nstate;
    cls_e              cls;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] hold;
    logic [31:0]       run_sum;
    logic              is_chk;

    cuc_id_filter i_filter (
        .valid   (frm_valid),
        .id      (frm_id),
        .node_id (node_id),
        .cls     (cls)
    );

    // next state: T_DATA, T_CTRL, T_STREAM_END, T_CTRL_END
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (cls == CLS_DAT)      nstate = ST_STREAM;
                else if (cls == CLS_CTL) nstate = ST_CTRL;
            end
            ST_STREAM: if (cnt == CNT_W'(FRAME_BYTES - 1)) nstate = ST_IDLE;
            ST_CTRL:   nstate = ST_IDLE;
            default:   nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            hold  <= '0;
        end else begin
            state <= nstate;
            if (state == ST_IDLE && cls != CLS_NONE) hold <= frm_data;
            if (state == ST_STREAM) cnt <= cnt + 1'b1;
            else                    cnt <= '0;
        end
    end

    always_comb begin
        byte_valid = 1'b0;
        byte_data  = '0;
        ctl_valid  = 1'b0;
        ctl_type   = '0;
        ctl_msg    = '0;
        is_chk     = 1'b0;
        sum_ok     = 1'b0;
        sum_bad    = 1'b0;
        unique case (state)
            ST_STREAM: begin
                byte_valid = 1'b1;
                byte_data  = hold[WORD_W - 1 - 8*int'(cnt) -: 8];
            end
            ST_CTRL: begin
                ctl_valid = 1'b1;
                ctl_type  = hold[63:32];
                ctl_msg   = hold[31:0];
                is_chk    = (hold[63:32] == CHK_CODE);
                sum_ok    = is_chk && (run_sum == hold[31:0]);
                sum_bad   = is_chk && (run_sum != hold[31:0]);
            end
            default: ;
        endcase
    end

    cuc_checksum #(.SUM_W(32)) i_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (byte_valid),
        .add_byte (byte_data),
        .clr      (is_chk),
        .sum      (run_sum)
    );

    cuc_addr_track #(.ADDR_W(ADDR_W)) i_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (byte_valid),
        .commit (sum_ok),
        .rewind (sum_bad),
        .addr   (byte_addr)
    );

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sum_ok, sum_bad})); // R8
    AST_FLAG_WITH_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_ok || sum_bad) |-> ctl_valid); // R8
    AST_KIND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && ctl_valid)); // R7
    AST_CTL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_valid |=> !ctl_valid); // R6
    AST_STREAM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && cnt != CNT_W'(FRAME_BYTES - 1)) |=> byte_valid); // R5
    AST_STREAM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && cnt == CNT_W'(FRAME_BYTES - 1)) |=> !byte_valid); // R7
endmodule

// File: tb/test_can_upd_classifier.sv
module test_can_upd_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  node_id = 8'd5;
    logic        frm_valid = 1'b0;
    logic [28:0] frm_id = '0;
    logic [63:0] frm_data = '0;
    logic        byte_valid, ctl_valid, sum_ok, sum_bad;
    logic [7:0]  byte_data;
    logic [23:0] byte_addr;
    logic [31:0] ctl_type, ctl_msg;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_upd_classifier i_can_upd_classifier (
        .clk(clk), .rst_n(rst_n), .node_id(node_id), .frm_valid(frm_valid),
        .frm_id(frm_id), .frm_data(frm_data), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_addr(byte_addr), .ctl_valid(ctl_valid),
        .ctl_type(ctl_type), .ctl_msg(ctl_msg), .sum_ok(sum_ok), .sum_bad(sum_bad)
    );

    function automatic logic [28:0] mk_id(bit dir, bit cast, logic [7:0] node,
                                          logic [7:0] kind, logic [10:0] rsv);
        return {dir, cast, node, rsv, kind};
    endfunction

    function automatic logic [31:0] bsum(logic [63:0] d);
        logic [31:0] s = 0;
        for (int i = 0; i < 8; i++) s += 32'(d[8*i +: 8]);
        return s;
    endfunction

    // kind: 0 dropped, 1 data, 2 control
    typedef struct packed {
        logic [28:0] id;
        logic [63:0] data;
        logic [1:0]  kind;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{29'h0000_050A, 64'h0102_0304_0506_0708, 2'd1}, // R3 broadcast data
        '{29'h0828_000A, 64'h8899_AABB_CCDD_EEF0, 2'd1}, // R3 addressed to 5
        '{29'h0830_000A, 64'h1111_1111_1111_1111, 2'd0}, // R3 addressed to 6
        '{29'h1000_000A, 64'h2222_2222_2222_2222, 2'd0}, // R2 from a node
        '{29'h0000_000B, 64'h3333_3333_3333_3333, 2'd0}, // R4 type 11
        '{29'h0828_0009, 64'h1234_5678_9ABC_DEF0, 2'd2}, // R6 control to 5
        '{29'h0007_FF09, 64'h0000_0042_0000_0077, 2'd2}, // R4 reserved bits set
        '{29'h0000_0000, 64'h4444_4444_4444_4444, 2'd0}  // R4 type 0
    };

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // captured results of one frame
    int          c_bytes, c_ctl, c_ok, c_bad;
    logic [63:0] c_word;
    logic [23:0] c_addr0;
    logic [31:0] c_type, c_msg;

    task automatic send(logic [28:0] id, logic [63:0] d, bit inject, logic [28:0] id2);
        c_bytes = 0; c_ctl = 0; c_ok = 0; c_bad = 0; c_word = '0;
        c_addr0 = '0; c_type = '0; c_msg = '0;
        @(negedge clk);
        frm_valid = 1'b1; frm_id = id; frm_data = d;
        @(negedge clk);
        frm_valid = 1'b0;
        for (int i = 0; i < 11; i++) begin
            if (byte_valid) begin
                if (c_bytes == 0) c_addr0 = byte_addr;
                if (c_bytes < 8) c_word = {c_word[55:0], byte_data};
                c_bytes++;
            end
            if (ctl_valid) begin c_ctl++; c_type = ctl_type; c_msg = ctl_msg; end
            if (sum_ok) c_ok++;
            if (sum_bad) c_bad++;
            if (inject && i == 2) begin
                frm_valid = 1'b1; frm_id = id2; frm_data = 64'h0000_0001_0000_0000;
            end else begin
                frm_valid = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        logic [23:0] exp_addr;
        logic [31:0] exp_sum;
        logic [63:0] dx;
        exp_addr = 0; exp_sum = 0;
        repeat (3) @(negedge clk);
        check(!byte_valid && !ctl_valid && !sum_ok && !sum_bad, "R1", "flags", 0, 0);
        check(byte_addr == 0, "R1", "addr", byte_addr, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            send(VEC[v].id, VEC[v].data, 0, '0);
            if (VEC[v].kind == 2'd1) begin
                check(c_bytes == 8 && c_ctl == 0, "R5", "byte count", c_bytes, 8);
                check(c_word == VEC[v].data, "R5", "byte order", c_word, VEC[v].data);
                check(c_addr0 == exp_addr, "R5", "first addr", c_addr0, exp_addr);
                exp_addr += 8; exp_sum += bsum(VEC[v].data);
            end else if (VEC[v].kind == 2'd2) begin
                check(c_ctl == 1 && c_bytes == 0, "R6", "ctl count", c_ctl, 1);
                check(c_type == VEC[v].data[63:32], "R6", "ctl type", c_type, VEC[v].data[63:32]);
                check(c_msg == VEC[v].data[31:0], "R6", "ctl msg", c_msg, VEC[v].data[31:0]);
                check(c_ok == 0 && c_bad == 0, "R8", "non-check flags", c_ok + c_bad, 0);
            end else begin
                check(c_bytes == 0 && c_ctl == 0, "R2/R3/R4", "dropped frame", c_bytes + c_ctl, 0);
            end
        end

        // R8 wrong sum
        send(29'h0000_0009, {32'h1, exp_sum + 32'd1}, 0, '0);
        check(c_bad == 1 && c_ok == 0, "R8", "mismatch flag", c_bad, 1);
        // R10 rewind, R9 clear on mismatch
        dx = 64'hDEAD_BEEF_0BAD_F00D;
        send(29'h0000_000A, dx, 0, '0);
        check(c_addr0 == 0, "R10", "rewound addr", c_addr0, 0);
        send(29'h0000_0009, {32'h1, bsum(dx)}, 0, '0);
        check(c_ok == 1 && c_bad == 0, "R9", "sum restarted after mismatch", c_ok, 1);
        // R10 commit, padding frame
        send(29'h0000_000A, 64'hFFFF_FFFF_FFFF_FFFF, 0, '0);
        check(c_addr0 == 8, "R10", "addr after match", c_addr0, 8);
        send(29'h0000_0009, {32'h1, 32'h0000_07F8}, 0, '0);
        check(c_ok == 1 && c_bad == 0, "R8", "0xFF padded sum", c_ok, 1);
        // R9 empty block
        send(29'h0000_0009, {32'h1, 32'h0}, 0, '0);
        check(c_ok == 1 && c_bad == 0, "R9", "cleared sum", c_ok, 1);
        // R7 strobe during stream
        send(29'h0000_000A, 64'h0A0B_0C0D_0E0F_1011, 1, 29'h0000_0009);
        check(c_bytes == 8 && c_ctl == 0, "R7", "overlap ignored", c_ctl, 0);
        check(c_addr0 == 16, "R7", "addr continues", c_addr0, 16);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule